// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache Controller

This block controls a small direct-mapped cache that sits between one processor and a shared, atomic snooping bus. Each line holds a tag, a data word and a single present/absent flag, so every line is either Valid or Invalid. A processor read that finds its line Valid is answered from the cache without using the bus. A read that misses wins the bus, fetches the word from the single-word memory port and fills the line. Every processor write goes to the bus as a write-through. A write that hits updates the cached word. A write that misses leaves the line untouched.

The controller also watches write transactions that other agents place on the bus. If such a write targets a word whose line is Valid here, that line becomes Invalid, so the next local read fetches the new value. The processor issues one operation at a time and waits for the completion pulse before it issues the next. Bus ownership uses a request/grant pair, and the controller changes no line for its own access until the grant is held.

Top module: `wtc_cache`

## Requirements
- R1: After reset `cpu_done`, `bus_req` and `bus_valid` are low and every line is Invalid, so the first read of any index makes exactly one bus read.
- R2: A read miss raises `bus_req` and then makes exactly one bus transaction with `bus_we`=0 and `bus_addr` equal to the request address. It returns `mem_rdata` of that transaction on `cpu_rdata` and leaves the line Valid.
- R3: A read hit makes no bus transaction. `cpu_done` rises in the second cycle after the cycle that samples `cpu_req`, and `cpu_rdata` carries the cached word.
- R4: Every processor write makes exactly one bus transaction with `bus_we`=1, `bus_addr` equal to the request address and `bus_wdata` equal to the written word. This holds for hits and misses.
- R5: A write miss does not allocate. The line stays Invalid for that address, and a following read of it makes a bus read.
- R6: A write hit stores the new word in the line and the line stays Valid. A following read of that address makes no bus transaction and returns the new word.
- R7: A bus write by another agent (`snoop_valid`=1, `snoop_we`=1) to an address whose line is Valid makes that line Invalid. The next local read then makes a bus read and returns the memory value.
- R8: A snooped bus read to a cached address has no effect on the line. A snooped write that has the same index but a different tag has no effect either. A following read of the cached address still hits.
- R9: The line index is `cpu_addr[INDEX_W-1:0]` and the tag is the remaining upper bits. A Valid line whose tag differs from the request tag counts as a miss, and the refill replaces the old tag.
- R10: The controller holds `bus_req` until `bus_gnt` is seen. It drives no bus transaction and changes no line for its own access before the grant, and `cpu_done` stays low while the grant is withheld.
- R11: `cpu_done` is a single-cycle pulse, issued once for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle pulse that starts a processor access |
| cpu_we | input | 1 | 1 = write, 0 = read, sampled with `cpu_req` |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_done` is high |
| cpu_done | output | 1 | Completion pulse for the access |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | This agent's bus transaction is in this cycle |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| mem_rdata | input | DATA_W | Memory word at `bus_addr`, valid in the transaction cycle |
| snoop_valid | input | 1 | Another agent's bus transaction is in this cycle |
| snoop_we | input | 1 | That transaction is a write |
| snoop_addr | input | ADDR_W | That transaction's address |

## Verification
Several properties are checked on every cycle. A snooped write that matches a Valid line clears it one cycle later. A bus write that misses leaves the request address absent. A read hit completes without raising `bus_req`. Each access makes at most one bus transaction, that transaction never starts in the cycle the request rises, and `cpu_done` never lasts two cycles. Only the directed scenarios can show the outcomes that depend on earlier history. These are cold misses after reset, data returned after a write hit, refetch after a snoop, index conflicts that evict a tag, and a stalled access waiting out a withheld grant.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    // Default geometry of the cache
    localparam int unsigned WTC_ADDR_W  = 8;
    localparam int unsigned WTC_DATA_W  = 16;
    localparam int unsigned WTC_INDEX_W = 2;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ARB,
        ST_XFER,
        ST_RESP
    } ctl_state_e;

    // Line operation requested by the sequencer for its own access
    typedef enum logic [1:0] {
        OP_NONE,
        OP_FILL,
        OP_UPDATE
    } line_op_e;

    function automatic logic is_own_change(line_op_e op);
        return op != OP_NONE;
    endfunction

endpackage

// File: rtl/wtc_line_array.sv
module wtc_line_array
    import wtc_pkg::*;
#(
    parameter int unsigned INDEX_W = WTC_INDEX_W,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned DATA_W  = WTC_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    output logic [DATA_W-1:0]  lk_data,
    input  line_op_e           op,
    input  logic [INDEX_W-1:0] op_idx,
    input  logic [TAG_W-1:0]   op_tag,
    input  logic [DATA_W-1:0]  op_data,
    input  logic               snp_wr,
    input  logic [INDEX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0]   snp_tag
);
    localparam int unsigned LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_w;
    logic [TAG_W-1:0] tag_w  [LINES];
    logic [DATA_W-1:0] data_w [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;
        logic              own_sel;
        logic              snp_sel;

        assign own_sel = is_own_change(op) && (op_idx == INDEX_W'(l));
        assign snp_sel = snp_wr && (snp_idx == INDEX_W'(l)) && v_q && (t_q == snp_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                t_q <= '0;
                d_q <= '0;
            end else if (own_sel) begin
                if (op == OP_FILL) begin
                    v_q <= 1'b1;
                    t_q <= op_tag;
                end
                d_q <= op_data;
            end else if (snp_sel) begin
                v_q <= 1'b0;
            end
        end

        assign valid_w[l] = v_q;
        assign tag_w[l]   = t_q;
        assign data_w[l]  = d_q;
    end

    assign lk_hit  = valid_w[lk_idx] && (tag_w[lk_idx] == lk_tag);
    assign lk_data = data_w[lk_idx];

    // R7
    snoop_invalidates_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_wr && !is_own_change(op) && valid_w[snp_idx] && tag_w[snp_idx] == snp_tag)
        |=> !valid_w[$past(snp_idx)]);

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int unsigned ADDR_W = WTC_ADDR_W,
    parameter int unsigned DATA_W = WTC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    input  logic              hit,
    input  logic [DATA_W-1:0] line_data,
    output logic [ADDR_W-1:0] req_addr,
    output line_op_e          op,
    output logic [DATA_W-1:0] op_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    ctl_state_e        state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              xfer_go;

    assign xfer_go = (state_q == ST_XFER) && bus_gnt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req) state_d = ST_CHECK;
            ST_CHECK: state_d = (!we_q && hit) ? ST_RESP : ST_ARB;
            ST_ARB:   if (bus_gnt) state_d = ST_XFER;
            ST_XFER:  if (bus_gnt) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op      = OP_NONE;
        op_data = we_q ? wdata_q : mem_rdata;
        if (xfer_go) begin
            if (!we_q)    op = OP_FILL;
            else if (hit) op = OP_UPDATE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req) begin
                we_q    <= cpu_we;
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end
            if (state_q == ST_CHECK) rdata_q <= line_data;
            if (xfer_go)             rdata_q <= we_q ? wdata_q : mem_rdata;
        end
    end

    assign req_addr  = addr_q;
    assign cpu_rdata = rdata_q;
    assign cpu_done  = (state_q == ST_RESP);
    assign bus_req   = (state_q == ST_ARB) || (state_q == ST_XFER);
    assign bus_valid = xfer_go;
    assign bus_we    = we_q;
    assign bus_wdata = wdata_q;

    // R3
    read_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && !we_q && hit) |=> (cpu_done && !bus_req));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    // R4
    single_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> !bus_valid);

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int unsigned ADDR_W  = WTC_ADDR_W,
    parameter int unsigned DATA_W  = WTC_DATA_W,
    parameter int unsigned INDEX_W = WTC_INDEX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snoop_valid,
    input  logic              snoop_we,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int unsigned TAG_W = ADDR_W - INDEX_W;

    logic [ADDR_W-1:0] req_addr;
    logic              hit;
    logic [DATA_W-1:0] line_data;
    line_op_e          op;
    logic [DATA_W-1:0] op_data;

    wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_done  (cpu_done),
        .hit       (hit),
        .line_data (line_data),
        .req_addr  (req_addr),
        .op        (op),
        .op_data   (op_data),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .mem_rdata (mem_rdata)
    );

    wtc_line_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (req_addr[INDEX_W-1:0]),
        .lk_tag  (req_addr[ADDR_W-1:INDEX_W]),
        .lk_hit  (hit),
        .lk_data (line_data),
        .op      (op),
        .op_idx  (req_addr[INDEX_W-1:0]),
        .op_tag  (req_addr[ADDR_W-1:INDEX_W]),
        .op_data (op_data),
        .snp_wr  (snoop_valid && snoop_we),
        .snp_idx (snoop_addr[INDEX_W-1:0]),
        .snp_tag (snoop_addr[ADDR_W-1:INDEX_W])
    );

    assign bus_addr = req_addr;

    // R5
    write_miss_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && !hit) |=> !hit);

    // R10
    grant_before_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !bus_valid);

endmodule

// File: tb/tb_wtc_cache.sv
module tb_wtc_cache;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata;
    logic          cpu_done;
    logic          bus_req, bus_gnt, bus_valid, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, mem_rdata;
    logic          snoop_valid, snoop_we;
    logic [AW-1:0] snoop_addr;
    logic [DW-1:0] snoop_wdata;
    logic          gnt_block;

    int n_tests = 0;
    int n_fail  = 0;
    int n_bus   = 0;
    logic          last_we;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_wdata;
    logic [DW-1:0] mem [256];

    always #5 clk = ~clk;

    wtc_cache dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mem_rdata(mem_rdata),
        .snoop_valid(snoop_valid), .snoop_we(snoop_we), .snoop_addr(snoop_addr)
    );

    // memory and arbiter models
    assign mem_rdata = mem[bus_addr];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = DW'(16'h0100 + i * 3);
    end

    always @(posedge clk) begin
        if (bus_valid && bus_we) mem[bus_addr] <= bus_wdata;
        if (snoop_valid && snoop_we) mem[snoop_addr] <= snoop_wdata;
        if (bus_valid) begin
            n_bus      <= n_bus + 1;
            last_we    <= bus_we;
            last_addr  <= bus_addr;
            last_wdata <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_gnt <= 1'b0;
        else     bus_gnt <= bus_req && !gnt_block;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int cyc, output int nb);
        int start;
        start = n_bus;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        cyc = 1;
        while (!cpu_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        nb = n_bus - start;
        @(negedge clk);
        // R11: completion is one cycle wide
        check(cpu_done == 1'b0, "R11", int'(cpu_done), 0);
    endtask

    task automatic snoop(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_we = we; snoop_addr = a; snoop_wdata = wd;
        @(negedge clk);
        snoop_valid = 1'b0; snoop_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] rd; int cyc, nb;
        check(!cpu_done && !bus_req && !bus_valid, "R1", {cpu_done, bus_req, bus_valid}, 0);
        for (int i = 0; i < 4; i++) begin
            access(1'b0, AW'(i), '0, rd, cyc, nb);
            check(nb == 1, "R1", nb, 1);
        end
    endtask

    task automatic t_read_miss_hit();
        logic [DW-1:0] rd, exp; int cyc, nb;
        exp = mem[8'h12];
        access(1'b0, 8'h12, '0, rd, cyc, nb);
        check(nb == 1 && last_we == 1'b0 && last_addr == 8'h12, "R2", nb, 1);
        check(rd == exp, "R2", rd, exp);
        access(1'b0, 8'h12, '0, rd, cyc, nb);
        check(nb == 0, "R3", nb, 0);
        check(cyc == 2, "R3", cyc, 2);
        check(rd == exp, "R3", rd, exp);
    endtask

    task automatic t_write_miss();
        logic [DW-1:0] rd; int cyc, nb;
        access(1'b1, 8'h23, 16'hBEEF, rd, cyc, nb);
        check(nb == 1 && last_we == 1'b1 && last_addr == 8'h23, "R4", nb, 1);
        check(last_wdata == 16'hBEEF, "R4", last_wdata, 16'hBEEF);
        access(1'b0, 8'h23, '0, rd, cyc, nb);
        check(nb == 1, "R5", nb, 1);
        check(rd == 16'hBEEF, "R5", rd, 16'hBEEF);
    endtask

    task automatic t_write_hit();
        logic [DW-1:0] rd; int cyc, nb;
        access(1'b0, 8'h31, '0, rd, cyc, nb);
        access(1'b1, 8'h31, 16'h5A5A, rd, cyc, nb);
        check(nb == 1 && last_we == 1'b1 && last_wdata == 16'h5A5A, "R4", nb, 1);
        access(1'b0, 8'h31, '0, rd, cyc, nb);
        check(nb == 0, "R6", nb, 0);
        check(rd == 16'h5A5A, "R6", rd, 16'h5A5A);
    endtask

    task automatic t_snoop_inv();
        logic [DW-1:0] rd; int cyc, nb;
        access(1'b0, 8'h12, '0, rd, cyc, nb);
        snoop(1'b1, 8'h12, 16'h7777);
        access(1'b0, 8'h12, '0, rd, cyc, nb);
        check(nb == 1, "R7", nb, 1);
        check(rd == 16'h7777, "R7", rd, 16'h7777);
    endtask

    task automatic t_snoop_other();
        logic [DW-1:0] rd; int cyc, nb;
        access(1'b0, 8'h12, '0, rd, cyc, nb);
        snoop(1'b0, 8'h12, '0);
        snoop(1'b1, 8'h22, 16'h1111);
        access(1'b0, 8'h12, '0, rd, cyc, nb);
        check(nb == 0, "R8", nb, 0);
        check(rd == 16'h7777, "R8", rd, 16'h7777);
    endtask

    task automatic t_conflict();
        logic [DW-1:0] rd, exp; int cyc, nb;
        exp = mem[8'h52];
        access(1'b0, 8'h52, '0, rd, cyc, nb);
        check(nb == 1 && rd == exp, "R9", nb, 1);
        access(1'b0, 8'h12, '0, rd, cyc, nb);
        check(nb == 1, "R9", nb, 1);
        access(1'b0, 8'h12, '0, rd, cyc, nb);
        check(nb == 0, "R9", nb, 0);
    endtask

    task automatic t_grant_wait();
        int start;
        bit early;
        logic [DW-1:0] exp;
        exp = mem[8'h40];
        start = n_bus;
        early = 1'b0;
        gnt_block = 1'b1;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h40;
        @(negedge clk);
        cpu_req = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cpu_done || bus_valid) early = 1'b1;
        end
        check(bus_req == 1'b1, "R10", int'(bus_req), 1);
        check(!early && n_bus == start, "R10", n_bus - start, 0);
        gnt_block = 1'b0;
        for (int i = 0; i < 20 && !cpu_done; i++) @(negedge clk);
        check(cpu_done && cpu_rdata == exp, "R10", cpu_rdata, exp);
        check(n_bus - start == 1, "R10", n_bus - start, 1);
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        snoop_valid = 1'b0; snoop_we = 1'b0; snoop_addr = '0; snoop_wdata = '0;
        gnt_block = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_write_miss();
        t_write_hit();
        t_snoop_inv();
        t_snoop_other();
        t_conflict();
        t_grant_wait();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule